// File: doc/BRIEF.md
# Parallel Single-Cycle Root Search for a GF(8) Error Locator

This block finds every root of a second-degree error-locator polynomial over GF(2^3) in one clock cycle. It evaluates all seven nonzero field elements side by side, so it can sit directly after a key-equation solver. Each new coefficient set accepted on the input strobe produces a complete error-position vector on the following cycle.

The polynomial is Λ(x) = λ0 + λ1·x + λ2·x². The field is generated by z³+z+1, and a field element is carried as three bits with bit 2 holding the z² coefficient. For each position i, the products λ1·α^i and λ2·α^(2i) are formed by fixed chains of one-bit left shifts. Each shift is followed by a reduction XOR when the top bit overflows. The XOR of the two products is then compared with λ0 rather than having λ0 added into it. The block also reports how many roots it found, saturated at three. A result of three can only come from a locator whose degree does not match the number of roots found, for example the all-zero polynomial.

A two-state sequencer drives the valid output. ST_IDLE is the reset state and the state held while no strobe arrives. ST_EMIT is entered on the edge where a strobe is accepted. The transitions are: IDLE→EMIT on a strobe, EMIT→EMIT on a strobe in the next cycle, EMIT→IDLE with no strobe, and IDLE→IDLE with no strobe.

Top module: `chien_par_search`

## Requirements
- R1: A strobe on valid_i in cycle k makes valid_o high in cycle k+1 carrying that set's result; valid_o is low in every cycle that does not follow a strobe, including back-to-back operation.
- R2: Position i (0..6) is a root exactly when λ1·α^i XOR λ2·α^(2i) equals λ0, with arithmetic in GF(8) modulo z³+z+1 and bit 2 as the z² coefficient; this is the same as Λ(α^i) = 0.
- R3: A root at α^i sets err_o bit (7−i) mod 7, so i=0 maps to bit 0 and i=k maps to bit 7−k for k=1..6; all other bits are 0.
- R4: For position 0, err_o bit 0 is 1 exactly when λ1 XOR λ2 equals λ0.
- R5: cnt_o equals the number of set bits in err_o, saturated at 3.
- R6: While valid_i is low, err_o and cnt_o keep their last values whatever the coefficient inputs do.
- R7: After reset, valid_o, err_o and cnt_o are all zero.
- R8: The all-zero coefficient set gives err_o = 7'b1111111 and cnt_o = 3.
- R9: For any set with λ2 nonzero, cnt_o is at most 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Coefficient set present this cycle |
| lam0_i | input | 3 | Constant coefficient λ0 |
| lam1_i | input | 3 | Linear coefficient λ1 |
| lam2_i | input | 3 | Quadratic coefficient λ2 |
| valid_o | output | 1 | Result registers hold a fresh result |
| err_o | output | 7 | Error-position vector, bit (7−i) mod 7 for root α^i |
| cnt_o | output | 2 | Number of roots found, saturated at 3 |

## Verification
Every coefficient input reaches the ports through a single register stage, so any internal fault appears on the cycle right after the strobe. A wrong reduction pattern or shift count in one position network corrupts one err_o bit for some of the 512 coefficient sets. A misrouted position shows up as a permuted vector, and a broken counter shows up as cnt_o disagreeing with the popcount of err_o. A sequencer stuck in either state appears as valid_o high with no strobe, or low after one, on that same next cycle.

// File: rtl/chien_pkg.sv
`timescale 1ns/1ps
package chien_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } cs_state_t;

    localparam int unsigned DEF_GF_M = 3;
    localparam logic [DEF_GF_M:0] DEF_FIELD_POLY = 4'b1011;
endpackage

// File: rtl/gf_alpha_pow.sv
`timescale 1ns/1ps
module gf_alpha_pow #(
    parameter int unsigned GF_M = 3,
    parameter logic [GF_M:0] FIELD_POLY = 4'b1011,
    parameter int unsigned SHIFTS = 0
) (
    input  logic [GF_M-1:0] a_i,
    output logic [GF_M-1:0] y_o
);
    logic [GF_M-1:0] stage [0:SHIFTS];

    assign stage[0] = a_i;

    // one multiply-by-alpha per step: shift left, fold the overflow back in
    for (genvar g = 0; g < SHIFTS; g++) begin : g_step
        assign stage[g+1] = {stage[g][GF_M-2:0], 1'b0}
                          ^ ({GF_M{stage[g][GF_M-1]}} & FIELD_POLY[GF_M-1:0]);
    end

    assign y_o = stage[SHIFTS];
endmodule

// File: rtl/chien_position.sv
`timescale 1ns/1ps
module chien_position #(
    parameter int unsigned GF_M = 3,
    parameter logic [GF_M:0] FIELD_POLY = 4'b1011,
    parameter int unsigned POS = 0
) (
    input  logic [GF_M-1:0] lam0_i,
    input  logic [GF_M-1:0] lam1_i,
    input  logic [GF_M-1:0] lam2_i,
    output logic            hit_o
);
    localparam int unsigned ORDER = (1 << GF_M) - 1;
    localparam int unsigned SH1   = POS % ORDER;
    localparam int unsigned SH2   = (2 * POS) % ORDER;

    logic [GF_M-1:0] term1;
    logic [GF_M-1:0] term2;

    gf_alpha_pow #(.GF_M(GF_M), .FIELD_POLY(FIELD_POLY), .SHIFTS(SH1)) u_t1 (
        .a_i(lam1_i),
        .y_o(term1)
    );

    gf_alpha_pow #(.GF_M(GF_M), .FIELD_POLY(FIELD_POLY), .SHIFTS(SH2)) u_t2 (
        .a_i(lam2_i),
        .y_o(term2)
    );

    // constant term is compared, not summed
    assign hit_o = ((term1 ^ term2) == lam0_i);
endmodule

// File: rtl/root_counter.sv
`timescale 1ns/1ps
module root_counter #(
    parameter int unsigned NPOS  = 7,
    parameter int unsigned CNT_W = 2
) (
    input  logic [NPOS-1:0]  hits_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int unsigned TW = $clog2(NPOS + 1);
    localparam logic [TW-1:0] SAT_MAX = TW'((1 << CNT_W) - 1);

    logic [TW-1:0] total;

    always_comb begin
        total = '0;
        for (int k = 0; k < NPOS; k++) begin
            total = total + {{(TW-1){1'b0}}, hits_i[k]};
        end
    end

    assign cnt_o = (total > SAT_MAX) ? SAT_MAX[CNT_W-1:0] : total[CNT_W-1:0];
endmodule

// File: rtl/chien_par_search.sv
`timescale 1ns/1ps
module chien_par_search
    import chien_pkg::*;
#(
    parameter int unsigned GF_M = DEF_GF_M,
    parameter logic [GF_M:0] FIELD_POLY = DEF_FIELD_POLY,
    parameter int unsigned CNT_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         valid_i,
    input  logic [GF_M-1:0]              lam0_i,
    input  logic [GF_M-1:0]              lam1_i,
    input  logic [GF_M-1:0]              lam2_i,
    output logic                         valid_o,
    output logic [(1 << GF_M) - 2:0]     err_o,
    output logic [CNT_W-1:0]             cnt_o
);
    localparam int unsigned NPOS    = (1 << GF_M) - 1;
    localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

    cs_state_t state_q, state_d;
    logic [NPOS-1:0]  err_d;
    logic [CNT_W-1:0] cnt_d;

    // one evaluator per nonzero field element, routed to bit (N-i) mod N
    for (genvar p = 0; p < NPOS; p++) begin : g_pos
        localparam int unsigned BITIX = (NPOS - p) % NPOS;
        chien_position #(.GF_M(GF_M), .FIELD_POLY(FIELD_POLY), .POS(p)) u_pos (
            .lam0_i(lam0_i),
            .lam1_i(lam1_i),
            .lam2_i(lam2_i),
            .hit_o (err_d[BITIX])
        );
    end

    root_counter #(.NPOS(NPOS), .CNT_W(CNT_W)) u_cnt (
        .hits_i(err_d),
        .cnt_o (cnt_d)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = valid_i ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = valid_i ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result registers, loaded only on an accepted strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_o <= '0;
            cnt_o <= '0;
        end else if (valid_i) begin
            err_o <= err_d;
            cnt_o <= cnt_d;
        end
    end

    assign valid_o = (state_q == ST_EMIT);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    // R1
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);
    // R4
    pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (err_o[0] == ($past(lam1_i ^ lam2_i) == $past(lam0_i))));
    // R5
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cnt_o == CNT_W'(($countones(err_o) > CNT_MAX) ? CNT_MAX : $countones(err_o))));
    // R6
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(err_o) && $stable(cnt_o)));
    // R8
    zero_poly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && lam0_i == '0 && lam1_i == '0 && lam2_i == '0) |=> (err_o == '1));
    // R9
    degree_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && lam2_i != '0) |=> ($countones(err_o) <= 2));
endmodule

// File: tb/chien_par_search_tb.sv
`timescale 1ns/1ps
module chien_par_search_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [2:0] lam0_i = '0, lam1_i = '0, lam2_i = '0;
    logic       valid_o;
    logic [6:0] err_o;
    logic [1:0] cnt_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    chien_par_search dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
        .lam0_i(lam0_i), .lam1_i(lam1_i), .lam2_i(lam2_i),
        .valid_o(valid_o), .err_o(err_o), .cnt_o(cnt_o)
    );

    // GF(8) multiply: carry-less product, then reduce by z^3+z+1
    function automatic logic [2:0] gmul(input logic [2:0] a, input logic [2:0] b);
        logic [4:0] p = '0;
        for (int k = 0; k < 3; k++) if (b[k]) p ^= ({2'b00, a} << k);
        for (int k = 4; k >= 3; k--) if (p[k]) p ^= (5'b01011 << (k - 3));
        return p[2:0];
    endfunction

    function automatic logic [6:0] model_err(input logic [2:0] l0, l1, l2);
        logic [6:0] e = '0;
        logic [2:0] x = 3'b001;
        for (int i = 0; i < 7; i++) begin
            if ((l0 ^ gmul(l1, x) ^ gmul(l2, gmul(x, x))) == 3'b000)
                e[(7 - i) % 7] = 1'b1;
            x = gmul(x, 3'b010);
        end
        return e;
    endfunction

    function automatic logic [1:0] model_cnt(input logic [6:0] e);
        int c = $countones(e);
        return (c > 3) ? 2'd3 : 2'(c);
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input bit v, input logic [2:0] l0, l1, l2);
        valid_i = v; lam0_i = l0; lam1_i = l1; lam2_i = l2;
    endtask

    // R7
    task automatic t_reset();
        @(negedge clk);
        check(valid_o == 1'b0, "R7 valid", 16'(valid_o), 16'h0);
        check(err_o == 7'h00, "R7 err", 16'(err_o), 16'h0);
        check(cnt_o == 2'd0, "R7 cnt", 16'(cnt_o), 16'h0);
    endtask

    // R8, R1
    task automatic t_all_zero();
        @(negedge clk); drive(1'b1, 3'd0, 3'd0, 3'd0);
        @(negedge clk); drive(1'b0, 3'd5, 3'd5, 3'd5);
        check(valid_o == 1'b1, "R1 valid after strobe", 16'(valid_o), 16'h1);
        check(err_o == 7'h7f, "R8 err all ones", 16'(err_o), 16'h7f);
        check(cnt_o == 2'd3, "R8 cnt saturated", 16'(cnt_o), 16'h3);
        @(negedge clk);
        check(valid_o == 1'b0, "R1 valid drops", 16'(valid_o), 16'h0);
    endtask

    // R4: position 0 matches when l1^l2 == l0
    task automatic t_position0();
        @(negedge clk); drive(1'b1, 3'd6, 3'd3, 3'd5);
        @(negedge clk); drive(1'b1, 3'd7, 3'd3, 3'd5);
        check(err_o[0] == 1'b1, "R4 pos0 hit", 16'(err_o[0]), 16'h1);
        @(negedge clk); drive(1'b0, 3'd0, 3'd0, 3'd0);
        check(err_o[0] == 1'b0, "R4 pos0 miss", 16'(err_o[0]), 16'h0);
    endtask

    // R2, R3, R5, R9, R1: all 512 sets, back-to-back strobes
    task automatic t_exhaustive();
        logic [6:0] exp_e;
        logic [1:0] exp_c;
        bit pend = 1'b0;
        logic [2:0] p0 = '0, p1 = '0, p2 = '0;
        for (int c = 0; c <= 512; c++) begin
            @(negedge clk);
            if (pend) begin
                exp_e = model_err(p0, p1, p2);
                exp_c = model_cnt(exp_e);
                check(valid_o == 1'b1, "R1 back-to-back valid", 16'(valid_o), 16'h1);
                check(err_o == exp_e, "R2/R3 err vector", 16'(err_o), 16'(exp_e));
                check(cnt_o == exp_c, "R5 count", 16'(cnt_o), 16'(exp_c));
                if (p2 != 3'd0)
                    check(cnt_o <= 2'd2, "R9 degree bound", 16'(cnt_o), 16'h2);
            end
            if (c < 512) begin
                p0 = 3'(c); p1 = 3'(c >> 3); p2 = 3'(c >> 6);
                drive(1'b1, p0, p1, p2);
                pend = 1'b1;
            end else begin
                drive(1'b0, 3'd0, 3'd0, 3'd0);
            end
        end
    endtask

    // R3: single known root alpha^1 of (x + alpha)(x + alpha^3) -> bits 6 and 4
    task automatic t_known_roots();
        // product: x^2 + (a^1+a^3)x + a^4 = x^2 + a^0*x? a+a^3 = 2^3=1 -> l1=1, l0=a^4=6
        @(negedge clk); drive(1'b1, 3'd6, 3'd1, 3'd1);
        @(negedge clk); drive(1'b0, 3'd0, 3'd0, 3'd0);
        check(err_o == 7'b1010000, "R3 roots a^1,a^3", 16'(err_o), 16'h50);
        check(cnt_o == 2'd2, "R5 two roots", 16'(cnt_o), 16'h2);
    endtask

    // R6: inputs wiggle with no strobe, outputs hold
    task automatic t_hold();
        logic [6:0] exp_e;
        @(negedge clk); drive(1'b1, 3'd4, 3'd2, 3'd7);
        @(negedge clk); drive(1'b0, 3'd0, 3'd0, 3'd0);
        exp_e = model_err(3'd4, 3'd2, 3'd7);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(valid_o == 1'b0, "R6 no valid while idle", 16'(valid_o), 16'h0);
            check(err_o == exp_e, "R6 err held", 16'(err_o), 16'(exp_e));
            check(cnt_o == model_cnt(exp_e), "R6 cnt held", 16'(cnt_o), 16'(model_cnt(exp_e)));
            drive(1'b0, 3'(k), 3'(k + 1), 3'(k + 2));
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_all_zero();
        t_position0();
        t_known_roots();
        t_exhaustive();
        t_hold();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule